// File: doc/BRIEF.md
# Receiver Bring-Up Phase Sequencer

This block moves a high-speed serial receiver through its power-up lock stages. A counter divides the reference clock to a one-microsecond tick, and the elapsed time is measured from the moment the sequence begins. While that time is early, the PLL is clamped at its lowest frequency so that bias currents can settle. The analog receiver is then allowed to lock. After that the data recovery loop is allowed to lock, a short settling window follows, and finally the parallel receive word is declared valid. Comma alignment is armed only in the valid phase.

The sequence runs only while reset, PLL bypass and sleep are all inactive. Reset forces the transmit output low, freezes the receive word, and clears the phase selector and the loop filter. Sleep powers the PLL down. Bypass parks the block with every control low. Leaving any of these three conditions starts the sequence again from time zero.

Once the data is valid, the receiver can be idled through a run-enable input. When run-enable returns, a short 2 µs relock brings the data back to valid without a full restart. All control inputs pass through two-flop synchronisers. The current phase is visible as a 4-bit code.

Top module: `lockseq_top`

## Requirements
- R1: While `rstN` is low, `phase` is 0 and `pllHoldMin`, `txForceZero`, `rxHoldWord` and `phaseSelReset` are 1, with every other control 0. After `rstN` rises, `phase` becomes 1 on the third rising clock edge.
- R2: Phase 1 (bias settle) drives only `pllHoldMin`. Phase 2 begins 32·CLK_PER_US+1 cycles after phase 1 is entered.
- R3: Phase 2 (analog lock) drives only `rxAnalogLockEn`. Phase 3 begins 262·CLK_PER_US+1 cycles after phase 1 is entered.
- R4: Phase 3 (data lock) and phase 4 (settle) drive `rxAnalogLockEn` and `dataLockEn`. Phase 4 begins 326·CLK_PER_US+1 cycles after phase 1 is entered.
- R5: Phase 5 (locked) begins 358·CLK_PER_US+1 cycles after phase 1 is entered. It drives `rxAnalogLockEn`, `dataLockEn` and `rxDataValid`. `rxDataValid` is 1 in no other phase.
- R6: `commaAlignEn` is 1 exactly when the phase is 5 and the synchronised `commaDetEn` is 1. A change on `commaDetEn` reaches the output on the second rising edge.
- R7: In phase 5, a low `refRunEn` leads to phase 6 (idle), which drives only `rxAnalogLockEn`. A high `refRunEn` then leads to phase 7 (relock), which drives `rxAnalogLockEn` and `dataLockEn`. Phase 5 is re-entered 2·CLK_PER_US+1 cycles after phase 7 begins.
- R8: While `sleepReq` is high, the phase is 8, which drives only `pllPowerDown`. On release, the phase returns to 1, and all timing restarts from zero.
- R9: While `bypassPll` is high, the phase is 9, with every control output 0. On release, the phase returns to 1, and all timing restarts from zero.
- R10: Reset takes priority over sleep, and sleep takes priority over bypass.
- R11: A change on `bypassPll`, `sleepReq` or `refRunEn` changes `phase` on the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| bypassPll | input | 1 | PLL bypass; holds the sequence |
| sleepReq | input | 1 | Low-power sleep request |
| refRunEn | input | 1 | Receiver run enable after lock; low idles |
| commaDetEn | input | 1 | Permits comma byte alignment |
| phase | output | 4 | Current phase code (0..9) |
| pllHoldMin | output | 1 | Clamp the PLL at minimum frequency |
| pllPowerDown | output | 1 | Power the PLL down |
| rxAnalogLockEn | output | 1 | Analog receiver lock-in enable |
| dataLockEn | output | 1 | Data recovery lock-in enable |
| rxDataValid | output | 1 | Parallel receive word valid |
| commaAlignEn | output | 1 | Comma byte alignment armed |
| phaseSelReset | output | 1 | Clears phase selector and loop filter |
| txForceZero | output | 1 | Forces the serial transmit output low |
| rxHoldWord | output | 1 | Freezes the parallel receive word |

## Verification
The hardest states to reach are interruptions that land deep in the timeline, such as sleep or bypass arriving during the settle window or after lock. Reaching each of these needs hundreds of microseconds of prior progress. The bench therefore runs with four clocks per microsecond and follows every cycle of the full timeline. It then replays the sequence once per phase and per interrupt kind, raising the interrupt in the middle of that phase. After each interrupt it checks the three-edge synchroniser latency and that a complete timing rerun follows.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  typedef enum logic [3:0] {
    PH_RESET  = 4'd0,
    PH_BIAS   = 4'd1,
    PH_ALOCK  = 4'd2,
    PH_DLOCK  = 4'd3,
    PH_SETTLE = 4'd4,
    PH_LOCKED = 4'd5,
    PH_IDLE   = 4'd6,
    PH_RELOCK = 4'd7,
    PH_SLEEP  = 4'd8,
    PH_HOLD   = 4'd9
  } phase_e;

  // control -> timebase strobes
  typedef struct packed {
    logic clrTime;
  } timeCtl_t;

  // synchronised conditions, timebase -> control
  typedef struct packed {
    logic rstActive;
    logic sleep;
    logic bypass;
    logic runEn;
    logic commaEn;
  } ctlIn_t;

endpackage

// File: rtl/lockseq_time.sv
module lockseq_time
  import lockseq_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int US_MAX     = 358,
  localparam int US_W      = $clog2(US_MAX + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bypassIn,
  input  logic            sleepIn,
  input  logic            runEnIn,
  input  logic            commaEnIn,
  input  timeCtl_t        timeCtl,
  output ctlIn_t          ctlIn,
  output logic [US_W-1:0] usCnt
);

  localparam int CYC_W  = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int N_SYNC = 4;

  logic [1:0]        rstPipe;
  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] syncOut;
  logic [CYC_W-1:0]  cycCnt;
  logic              usTick;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= 2'b00;
    else       rstPipe <= {rstPipe[0], 1'b1};
  end

  assign rawIn = {sleepIn, bypassIn, runEnIn, commaEnIn};

  for (genvar g = 0; g < N_SYNC; g++) begin : gSync
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= 2'b00;
      else       stage <= {stage[0], rawIn[g]};
    end
    assign syncOut[g] = stage[1];
  end

  assign ctlIn.rstActive = ~rstPipe[1];
  assign ctlIn.sleep     = syncOut[3];
  assign ctlIn.bypass    = syncOut[2];
  assign ctlIn.runEn     = syncOut[1];
  assign ctlIn.commaEn   = syncOut[0];

  // microsecond timebase
  assign usTick = (cycCnt == CYC_W'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (timeCtl.clrTime) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else begin
      cycCnt <= usTick ? '0 : cycCnt + 1'b1;
      if (usTick && (usCnt != US_W'(US_MAX))) usCnt <= usCnt + 1'b1;
    end
  end

  assert_us_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!timeCtl.clrTime && usTick && usCnt != US_W'(US_MAX)) |=> usCnt == $past(usCnt) + 1'b1);

  assert_us_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeCtl.clrTime |=> usCnt == '0);

endmodule

// File: rtl/lockseq_ctrl.sv
module lockseq_ctrl
  import lockseq_pkg::*;
#(
  parameter int US_W     = 9,
  parameter int T_BIAS   = 32,
  parameter int T_ALOCK  = 262,
  parameter int T_DLOCK  = 326,
  parameter int T_VALID  = 358,
  parameter int T_RELOCK = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlIn_t          ctlIn,
  input  logic [US_W-1:0] usCnt,
  output timeCtl_t        timeCtl,
  output phase_e          phase,
  output logic            pllHoldMin,
  output logic            pllPowerDown,
  output logic            rxAnalogLockEn,
  output logic            dataLockEn,
  output logic            rxDataValid,
  output logic            commaAlignEn,
  output logic            phaseSelReset,
  output logic            txForceZero,
  output logic            rxHoldWord
);

  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    if (ctlIn.rstActive)   phaseNext = PH_RESET;
    else if (ctlIn.sleep)  phaseNext = PH_SLEEP;
    else if (ctlIn.bypass) phaseNext = PH_HOLD;
    else begin
      unique case (phase)
        PH_RESET, PH_SLEEP, PH_HOLD: phaseNext = PH_BIAS;
        PH_BIAS:   if (usCnt >= US_W'(T_BIAS))  phaseNext = PH_ALOCK;
        PH_ALOCK:  if (usCnt >= US_W'(T_ALOCK)) phaseNext = PH_DLOCK;
        PH_DLOCK:  if (usCnt >= US_W'(T_DLOCK)) phaseNext = PH_SETTLE;
        PH_SETTLE: if (usCnt >= US_W'(T_VALID)) phaseNext = PH_LOCKED;
        PH_LOCKED: if (!ctlIn.runEn)            phaseNext = PH_IDLE;
        PH_IDLE:   if (ctlIn.runEn)             phaseNext = PH_RELOCK;
        PH_RELOCK: begin
          if (!ctlIn.runEn)                     phaseNext = PH_IDLE;
          else if (usCnt >= US_W'(T_RELOCK))    phaseNext = PH_LOCKED;
        end
        default: phaseNext = PH_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RESET;
    else       phase <= phaseNext;
  end

  // time restarts from zero whenever the next timed stretch will begin
  assign timeCtl.clrTime = (phase == PH_RESET) || (phase == PH_SLEEP) ||
                           (phase == PH_HOLD)  || (phase == PH_IDLE);

  always_comb begin
    pllHoldMin     = 1'b0;
    pllPowerDown   = 1'b0;
    rxAnalogLockEn = 1'b0;
    dataLockEn     = 1'b0;
    rxDataValid    = 1'b0;
    commaAlignEn   = 1'b0;
    phaseSelReset  = 1'b0;
    txForceZero    = 1'b0;
    rxHoldWord     = 1'b0;
    unique case (phase)
      PH_RESET: begin
        pllHoldMin    = 1'b1;
        phaseSelReset = 1'b1;
        txForceZero   = 1'b1;
        rxHoldWord    = 1'b1;
      end
      PH_BIAS:  pllHoldMin     = 1'b1;
      PH_ALOCK: rxAnalogLockEn = 1'b1;
      PH_DLOCK, PH_SETTLE, PH_RELOCK: begin
        rxAnalogLockEn = 1'b1;
        dataLockEn     = 1'b1;
      end
      PH_LOCKED: begin
        rxAnalogLockEn = 1'b1;
        dataLockEn     = 1'b1;
        rxDataValid    = 1'b1;
        commaAlignEn   = ctlIn.commaEn;
      end
      PH_IDLE:  rxAnalogLockEn = 1'b1;
      PH_SLEEP: pllPowerDown   = 1'b1;
      default: ;
    endcase
  end

  assert_bias_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BIAS) |-> usCnt <= US_W'(T_BIAS));

  assert_valid_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDataValid) |-> ($past(phase) == PH_SETTLE || $past(phase) == PH_RELOCK));

  assert_valid_time_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDataValid) && $past(phase) == PH_SETTLE) |-> $past(usCnt) >= US_W'(T_VALID));

  assert_relock_time_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDataValid) && $past(phase) == PH_RELOCK) |-> $past(usCnt) >= US_W'(T_RELOCK));

  assert_idle_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOCKED && !ctlIn.runEn && !ctlIn.sleep && !ctlIn.bypass && !ctlIn.rstActive)
    |=> !rxDataValid);

  assert_sleep_powerdown_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIn.sleep && !ctlIn.rstActive) |=> pllPowerDown);

  assert_bypass_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIn.bypass && !ctlIn.sleep && !ctlIn.rstActive) |=> (phase == PH_HOLD));

endmodule

// File: rtl/lockseq_top.sv
module lockseq_top
  import lockseq_pkg::*;
#(
  parameter int CLK_PER_US = 125,
  parameter int T_BIAS     = 32,
  parameter int T_ALOCK    = 262,
  parameter int T_DLOCK    = 326,
  parameter int T_VALID    = 358,
  parameter int T_RELOCK   = 2,
  localparam int US_W      = $clog2(T_VALID + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bypassPll,
  input  logic       sleepReq,
  input  logic       refRunEn,
  input  logic       commaDetEn,
  output logic [3:0] phase,
  output logic       pllHoldMin,
  output logic       pllPowerDown,
  output logic       rxAnalogLockEn,
  output logic       dataLockEn,
  output logic       rxDataValid,
  output logic       commaAlignEn,
  output logic       phaseSelReset,
  output logic       txForceZero,
  output logic       rxHoldWord
);

  timeCtl_t        timeCtl;
  ctlIn_t          ctlIn;
  logic [US_W-1:0] usCnt;
  phase_e          phaseCur;

  lockseq_time #(
    .CLK_PER_US(CLK_PER_US),
    .US_MAX    (T_VALID)
  ) uTime (
    .clk      (clk),
    .rstN     (rstN),
    .bypassIn (bypassPll),
    .sleepIn  (sleepReq),
    .runEnIn  (refRunEn),
    .commaEnIn(commaDetEn),
    .timeCtl  (timeCtl),
    .ctlIn    (ctlIn),
    .usCnt    (usCnt)
  );

  lockseq_ctrl #(
    .US_W    (US_W),
    .T_BIAS  (T_BIAS),
    .T_ALOCK (T_ALOCK),
    .T_DLOCK (T_DLOCK),
    .T_VALID (T_VALID),
    .T_RELOCK(T_RELOCK)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .ctlIn         (ctlIn),
    .usCnt         (usCnt),
    .timeCtl       (timeCtl),
    .phase         (phaseCur),
    .pllHoldMin    (pllHoldMin),
    .pllPowerDown  (pllPowerDown),
    .rxAnalogLockEn(rxAnalogLockEn),
    .dataLockEn    (dataLockEn),
    .rxDataValid   (rxDataValid),
    .commaAlignEn  (commaAlignEn),
    .phaseSelReset (phaseSelReset),
    .txForceZero   (txForceZero),
    .rxHoldWord    (rxHoldWord)
  );

  assign phase = phaseCur;

endmodule

// File: tb/sim_lockseq_top.sv
module sim_lockseq_top;

  localparam int D = 4;              // clocks per microsecond in this bench
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypassPll = 1'b0;
  logic sleepReq = 1'b0;
  logic refRunEn = 1'b1;
  logic commaDetEn = 1'b0;
  logic [3:0] phase;
  logic pllHoldMin, pllPowerDown, rxAnalogLockEn, dataLockEn, rxDataValid;
  logic commaAlignEn, phaseSelReset, txForceZero, rxHoldWord;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lockseq_top #(.CLK_PER_US(D)) u0 (
    .clk(clk), .rstN(rstN), .bypassPll(bypassPll), .sleepReq(sleepReq),
    .refRunEn(refRunEn), .commaDetEn(commaDetEn), .phase(phase),
    .pllHoldMin(pllHoldMin), .pllPowerDown(pllPowerDown),
    .rxAnalogLockEn(rxAnalogLockEn), .dataLockEn(dataLockEn),
    .rxDataValid(rxDataValid), .commaAlignEn(commaAlignEn),
    .phaseSelReset(phaseSelReset), .txForceZero(txForceZero),
    .rxHoldWord(rxHoldWord)
  );

  // bit order: hold, pd, ana, dl, valid, comma, psr, tx0, hw
  function automatic logic [8:0] expOut(int ph, logic c);
    case (ph)
      0: return 9'b1_0_0_0_0_0_1_1_1;
      1: return 9'b1_0_0_0_0_0_0_0_0;
      2: return 9'b0_0_1_0_0_0_0_0_0;
      3, 4, 7: return 9'b0_0_1_1_0_0_0_0_0;
      5: return {5'b0_0_1_1_1, c, 3'b000};
      6: return 9'b0_0_1_0_0_0_0_0_0;
      8: return 9'b0_1_0_0_0_0_0_0_0;
      default: return 9'b0;
    endcase
  endfunction

  function automatic int seqPhase(int k);
    if (k <= 32 * D)  return 1;
    if (k <= 262 * D) return 2;
    if (k <= 326 * D) return 3;
    if (k <= 358 * D) return 4;
    return 5;
  endfunction

  function automatic string seqReq(int ph);
    case (ph)
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic chk(int expPh, logic expC, string req);
    logic [8:0] act;
    logic [8:0] ex;
    act = {pllHoldMin, pllPowerDown, rxAnalogLockEn, dataLockEn, rxDataValid,
           commaAlignEn, phaseSelReset, txForceZero, rxHoldWord};
    ex = expOut(expPh, expC);
    nChk++;
    if (phase !== expPh[3:0] || act !== ex) begin
      nBad++;
      $display("FAIL %s: phase=%0d outs=%b expected phase=%0d outs=%b",
               req, phase, act, expPh, ex);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #3;
    end
  endtask

  // leaves the bench one sample after entry into phase 1
  task automatic startSeq();
    rstN = 1'b0;
    #1;
    chk(0, 1'b0, "R1 reset asserted");
    step(2);
    rstN = 1'b1;
    step(2);
    chk(0, 1'b0, "R1 still in reset after two edges");
    step(1);
    chk(1, 1'b0, "R1 sequence start");
  endtask

  initial begin
    #(WATCHDOG * 10);
    nChk++;
    nBad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    int mids[5];
    mids[0] = 16 * D;
    mids[1] = 100 * D;
    mids[2] = 300 * D;
    mids[3] = 340 * D;
    mids[4] = 360 * D;

    step(3);
    chk(0, 1'b0, "R1 reset state");

    // full timeline sweep, every cycle
    startSeq();
    for (int k = 1; k <= 358 * D + 4; k++) begin
      step(1);
      chk(seqPhase(k), commaDetEn, seqReq(seqPhase(k)));
    end

    // comma alignment gating and synchroniser delay
    commaDetEn = 1'b1;
    step(1);
    chk(5, 1'b0, "R6 comma not yet synchronised");
    step(1);
    chk(5, 1'b1, "R6 comma armed");
    commaDetEn = 1'b0;
    step(2);
    chk(5, 1'b0, "R6 comma disarmed");
    commaDetEn = 1'b1;
    step(2);

    // idle and fast relock, several idle lengths
    for (int idleLen = 1; idleLen <= 3; idleLen++) begin
      refRunEn = 1'b0;
      step(2);
      chk(5, 1'b1, "R11 run drop not yet seen");
      step(1);
      chk(6, 1'b1, "R7 idle");
      step(idleLen * D);
      chk(6, 1'b1, "R7 idle held");
      refRunEn = 1'b1;
      step(3);
      chk(7, 1'b1, "R7 relock entry");
      for (int k = 1; k <= 2 * D + 2; k++) begin
        step(1);
        chk((k <= 2 * D) ? 7 : 5, 1'b1, "R7 relock timing");
      end
    end
    commaDetEn = 1'b0;

    // interrupts landing in each phase
    for (int mode = 0; mode < 3; mode++) begin
      for (int p = 0; p < 5; p++) begin
        startSeq();
        step(mids[p]);
        chk(seqPhase(mids[p]), 1'b0, "R5 timeline before interrupt");
        if (mode == 2) begin
          rstN = 1'b0;
          #1;
          chk(0, 1'b0, "R1 asynchronous reset");
          step(3);
          chk(0, 1'b0, "R1 reset held");
          rstN = 1'b1;
          step(2);
          chk(0, 1'b0, "R1 release latency");
          step(1);
          chk(1, 1'b0, "R1 restart");
        end else begin
          if (mode == 0) sleepReq = 1'b1;
          else           bypassPll = 1'b1;
          step(2);
          chk(seqPhase(mids[p] + 2), 1'b0, "R11 request not yet seen");
          step(1);
          chk(mode == 0 ? 8 : 9, 1'b0, mode == 0 ? "R8 sleep" : "R9 bypass");
          step(5);
          chk(mode == 0 ? 8 : 9, 1'b0, mode == 0 ? "R8 sleep held" : "R9 bypass held");
          sleepReq = 1'b0;
          bypassPll = 1'b0;
          step(2);
          chk(mode == 0 ? 8 : 9, 1'b0, "R11 release not yet seen");
          step(1);
          chk(1, 1'b0, mode == 0 ? "R8 restart" : "R9 restart");
        end
        step(32 * D);
        chk(1, 1'b0, mode == 0 ? "R8 rerun from zero" : "R9 rerun from zero");
        step(1);
        chk(2, 1'b0, mode == 0 ? "R8 rerun timing" : "R9 rerun timing");
      end
    end

    // priority between reset, sleep and bypass
    startSeq();
    step(10);
    sleepReq = 1'b1;
    bypassPll = 1'b1;
    step(3);
    chk(8, 1'b0, "R10 sleep over bypass");
    sleepReq = 1'b0;
    step(3);
    chk(9, 1'b0, "R10 bypass after sleep");
    sleepReq = 1'b1;
    rstN = 1'b0;
    #1;
    chk(0, 1'b0, "R10 reset over sleep");
    step(4);
    chk(0, 1'b0, "R10 reset held over sleep");
    rstN = 1'b1;
    step(3);
    chk(8, 1'b0, "R10 sleep after reset");
    sleepReq = 1'b0;
    step(3);
    chk(9, 1'b0, "R10 bypass still active");
    bypassPll = 1'b0;
    step(3);
    chk(1, 1'b0, "R9 restart after priority test");

    summary();
  end

endmodule